// File: doc/BRIEF.md
# Line Voltage Sag Detector

This block watches the filtered voltage sample stream of a single-phase metering front end and raises a sticky sag flag when the magnitude of the line voltage has stayed under a programmable level for a programmed number of full line cycles. Line cycles are delimited by a one-clock zero-crossing pulse produced elsewhere from the same filtered signal. The comparison uses the magnitude of each valid signed sample, so positive and negative half-waves are treated alike.

The cycle register holds one more than the number of full line cycles that must pass. A drop below the level arms the detector. The next zero-crossing pulse opens the first full cycle, and each later pulse closes one. With a programmed value N, the flag is set on the N-th zero-crossing pulse after the drop, which closes the (N-1)-th full cycle. Any valid sample at or above the level abandons the count. The flag stays set until software pulses a clear. An interrupt output follows the flag, gated by an enable.

The control is a four-state machine. **NORMAL** is the state after reset and means the voltage is healthy. A below-level sample moves it to **ARMED** (transition *drop*). In ARMED, a zero-crossing pulse moves it to **COUNT** with the cycle count at zero (transition *open*). In COUNT, each pulse adds one completed cycle (transition *tick*). The pulse that completes the required number of cycles sets the flag and moves to **HOLD** (transition *detect*). From ARMED, COUNT or HOLD, a valid at-or-above-level sample returns to NORMAL (transition *recover*). Recovery wins over a zero-crossing pulse that arrives in the same clock.

Top module: `vsag_monitor`

## Requirements
- R1: A valid sample counts as below the level when the magnitude of the 24-bit two's-complement sample is less than the 16-bit level shifted left by 8 bits. A magnitude equal to that value is not below the level. Negative samples use their absolute value.
- R2: A level of 0 or 1 sets the threshold to zero. No sample is then below it, and the flag is never set.
- R3: With cycle value N, the flag is set on the clock edge that samples the N-th zero-crossing pulse after the first below-level sample, provided that every valid sample in between is below the level. A pulse in the same clock as the dropping sample does not count.
- R4: A cycle value of 0 or 1 behaves as 2: the flag is set on the second pulse after the drop.
- R5: A valid sample at or above the level before the count completes restarts detection. A new drop and N new pulses are then needed.
- R6: After a detection, the flag is not set again until a recovery sample and a new full count have occurred. This holds even if software clears the flag while the sag persists.
- R7: The flag is sticky. A one-clock clear pulse drops it on the next edge. A set and a clear in the same clock leave the flag set.
- R8: The interrupt output is high exactly while both the flag and the interrupt enable are high, and it follows a change of the enable in the same clock.
- R9: After reset, the flag and the interrupt are low and the machine is in NORMAL.
- R10: A zero-crossing pulse that arrives in the same clock as a recovery sample is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | 24 | Filtered voltage sample, two's complement |
| zx_pulse | input | 1 | One-clock zero-crossing pulse, one per line cycle |
| sag_level | input | 16 | Sag threshold level |
| sag_cycles | input | 8 | Required full cycles plus one; 0 and 1 act as 2 |
| flag_clr | input | 1 | Software clear of the sag flag |
| irq_en | input | 1 | Interrupt enable |
| sag_flag | output | 1 | Sticky sag flag |
| sag_irq | output | 1 | Interrupt request |

## Verification
The flag is registered. It changes on the same edge that samples the deciding zero-crossing pulse or clear pulse. The interrupt is combinational from the flag and the enable, so an enable change shows up at once. The bench drives its inputs after a falling edge and compares both outputs against its own model at the next falling edge. This places every comparison half a period after the edge where a result becomes due. Directed checks then confirm the cycle counts of the requirements at the exact zero-crossing in each scenario where the flag must or must not have risen.

// File: rtl/vsag_pkg.sv
package vsag_pkg;

    typedef enum logic [1:0] {
        SAG_NORMAL = 2'd0,
        SAG_ARMED  = 2'd1,
        SAG_COUNT  = 2'd2,
        SAG_HOLD   = 2'd3
    } sag_state_t;

endpackage

// File: rtl/vsag_level_cmp.sv
module vsag_level_cmp #(
    parameter int SAMPLE_W = 24,
    parameter int LEVEL_W  = 16
) (
    input  logic                smp_valid_i,
    input  logic [SAMPLE_W-1:0] smp_data_i,
    input  logic [LEVEL_W-1:0]  level_i,
    output logic                below_o,
    output logic                above_o
);
    localparam int SHIFT = SAMPLE_W - LEVEL_W;

    logic [SAMPLE_W-1:0] mag;
    logic [SAMPLE_W-1:0] thresh;
    logic                level_live;

    // magnitude; the most negative code maps to 2^(SAMPLE_W-1), still representable unsigned
    assign mag = smp_data_i[SAMPLE_W-1] ? (~smp_data_i + 1'b1) : smp_data_i;

    generate
        if (SHIFT > 0) begin : g_scaled
            assign thresh = {level_i, {SHIFT{1'b0}}};
        end else begin : g_direct
            assign thresh = SAMPLE_W'(level_i);
        end
    endgenerate

    // levels 0 and 1 pin the threshold to zero
    assign level_live = (level_i > LEVEL_W'(1));
    assign below_o    = smp_valid_i && level_live && (mag < thresh);
    assign above_o    = smp_valid_i && !below_o;

endmodule

// File: rtl/vsag_cycle_fsm.sv
module vsag_cycle_fsm
    import vsag_pkg::*;
#(
    parameter int CYC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             below_i,
    input  logic             above_i,
    input  logic             zx_i,
    input  logic [CYC_W-1:0] cyc_cfg_i,
    output logic             sag_set_o
);
    localparam logic [CYC_W-1:0] MIN_CYC = CYC_W'(2);
    localparam logic [CYC_W-1:0] ONE     = CYC_W'(1);

    sag_state_t       state_q, state_d;
    logic [CYC_W-1:0] cnt_q, cnt_d;
    logic [CYC_W-1:0] eff_cyc;
    logic [CYC_W-1:0] target;
    logic             done;

    assign eff_cyc = (cyc_cfg_i < MIN_CYC) ? MIN_CYC : cyc_cfg_i;
    assign target  = eff_cyc - ONE;
    assign done    = ((cnt_q + ONE) == target);

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            SAG_NORMAL: begin
                if (below_i) begin
                    state_d = SAG_ARMED;        // drop
                    cnt_d   = '0;
                end
            end
            SAG_ARMED: begin
                if (above_i) begin
                    state_d = SAG_NORMAL;       // recover
                end else if (zx_i) begin
                    state_d = SAG_COUNT;        // open
                    cnt_d   = '0;
                end
            end
            SAG_COUNT: begin
                if (above_i) begin
                    state_d = SAG_NORMAL;       // recover
                end else if (zx_i) begin
                    if (done) begin
                        state_d = SAG_HOLD;     // detect
                    end else begin
                        cnt_d   = cnt_q + ONE;  // tick
                    end
                end
            end
            SAG_HOLD: begin
                if (above_i) begin
                    state_d = SAG_NORMAL;       // recover
                end
            end
            default: state_d = SAG_NORMAL;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SAG_NORMAL;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // outputs
    always_comb begin
        sag_set_o = 1'b0;
        unique case (state_q)
            SAG_COUNT: sag_set_o = zx_i && !above_i && done;
            default:   sag_set_o = 1'b0;
        endcase
    end

    assert_recover_R5: assert property (@(posedge clk) disable iff (!rst_n)
        above_i |=> (state_q == SAG_NORMAL));

    assert_hold_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == SAG_HOLD) && ($past(state_q) != SAG_HOLD)) |-> $past(zx_i));

    assert_no_count_on_recover_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (above_i && zx_i) |=> (state_q == SAG_NORMAL));

endmodule

// File: rtl/vsag_flag_ctrl.sv
module vsag_flag_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    input  logic irq_en_i,
    output logic flag_o,
    output logic irq_o
);
    logic flag_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (set_i) begin
            flag_q <= 1'b1;
        end else if (clr_i) begin
            flag_q <= 1'b0;
        end
    end

    assign flag_o = flag_q;
    assign irq_o  = flag_q && irq_en_i;

    assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i && clr_i) |=> flag_o);

    assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !flag_o);

    assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !clr_i) |=> flag_o);

endmodule

// File: rtl/vsag_monitor.sv
module vsag_monitor #(
    parameter int SAMPLE_W = 24,
    parameter int LEVEL_W  = 16,
    parameter int CYC_W    = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp_data,
    input  logic                zx_pulse,
    input  logic [LEVEL_W-1:0]  sag_level,
    input  logic [CYC_W-1:0]    sag_cycles,
    input  logic                flag_clr,
    input  logic                irq_en,
    output logic                sag_flag,
    output logic                sag_irq
);
    logic below;
    logic above;
    logic sag_set;

    vsag_level_cmp #(.SAMPLE_W(SAMPLE_W), .LEVEL_W(LEVEL_W)) u_cmp (
        .smp_valid_i (smp_valid),
        .smp_data_i  (smp_data),
        .level_i     (sag_level),
        .below_o     (below),
        .above_o     (above)
    );

    vsag_cycle_fsm #(.CYC_W(CYC_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .below_i   (below),
        .above_i   (above),
        .zx_i      (zx_pulse),
        .cyc_cfg_i (sag_cycles),
        .sag_set_o (sag_set)
    );

    vsag_flag_ctrl u_flag (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (sag_set),
        .clr_i    (flag_clr),
        .irq_en_i (irq_en),
        .flag_o   (sag_flag),
        .irq_o    (sag_irq)
    );

    assert_zero_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sag_level <= LEVEL_W'(1)) |-> !below);

    assert_set_on_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sag_set |-> (zx_pulse && smp_valid == below));

endmodule

// File: tb/vsag_monitor_tb.sv
module vsag_monitor_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_valid = 1'b0;
    logic [23:0] smp_data = '0;
    logic        zx_pulse = 1'b0;
    logic [15:0] sag_level = 16'h1000;
    logic [7:0]  sag_cycles = 8'd4;
    logic        flag_clr = 1'b0;
    logic        irq_en = 1'b1;
    logic        sag_flag;
    logic        sag_irq;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    vsag_monitor u_dut (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .zx_pulse(zx_pulse), .sag_level(sag_level), .sag_cycles(sag_cycles),
        .flag_clr(flag_clr), .irq_en(irq_en), .sag_flag(sag_flag), .sag_irq(sag_irq)
    );

    // behavioural reference: 0 normal, 1 armed, 2 counting, 3 holding
    int ref_st = 0;
    int ref_cnt = 0;
    bit ref_flag = 0;

    always @(posedge clk) begin
        int s, mag, need;
        bit blw, abv, set;
        if (!rst_n) begin
            ref_st = 0; ref_cnt = 0; ref_flag = 0;
        end else begin
            s    = int'($signed(smp_data));
            mag  = (s < 0) ? -s : s;
            blw  = smp_valid && (sag_level > 1) && (mag < (int'(sag_level) * 256));
            abv  = smp_valid && !blw;
            need = ((sag_cycles < 2) ? 2 : int'(sag_cycles)) - 1;
            set  = 0;
            case (ref_st)
                0: if (blw) begin ref_st = 1; ref_cnt = 0; end
                1: if (abv) ref_st = 0; else if (zx_pulse) begin ref_st = 2; ref_cnt = 0; end
                2: if (abv) ref_st = 0;
                   else if (zx_pulse) begin
                       if (ref_cnt + 1 == need) begin set = 1; ref_st = 3; end
                       else ref_cnt = ref_cnt + 1;
                   end
                default: if (abv) ref_st = 0;
            endcase
            if (set) ref_flag = 1;
            else if (flag_clr) ref_flag = 0;
        end
    end

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    // one clock of stimulus, then compare against the model half a period later
    task automatic step(input logic v, input logic [23:0] s, input logic z);
        smp_valid = v; smp_data = s; zx_pulse = z;
        @(posedge clk);
        @(negedge clk);
        chk("R3 R7 model flag", sag_flag, ref_flag);
        chk("R8 model irq", sag_irq, ref_flag && irq_en);
        flag_clr = 1'b0;
    endtask

    // eight clocks per line cycle, pulse on the first, samples on even clocks
    task automatic run_cycles(input int n, input int amp);
        for (int c = 0; c < n; c++) begin
            for (int k = 0; k < 8; k++) begin
                step(k % 2 == 0, (k < 4) ? 24'(amp) : 24'(-amp), k == 0);
            end
        end
    endtask

    task automatic clear_flag();
        flag_clr = 1'b1;
        step(1'b0, '0, 1'b0);
    endtask

    localparam int BIG   = 32'h300000;
    localparam int SMALL = 32'h050000;

    initial begin
        repeat (3) @(negedge clk);
        chk("R9 flag after reset", sag_flag, 1'b0);
        chk("R9 irq after reset", sag_irq, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        // basic detection, N = 4
        run_cycles(3, BIG);
        run_cycles(4, SMALL);
        chk("R3 not before 4th pulse", sag_flag, 1'b0);
        step(1'b1, 24'(SMALL), 1'b1);
        chk("R3 set on 4th pulse", sag_flag, 1'b1);
        chk("R8 irq with enable", sag_irq, 1'b1);
        step(1'b0, '0, 1'b0);
        run_cycles(1, SMALL);

        // cleared during a persisting sag: no re-trigger
        clear_flag();
        chk("R7 clear pulse", sag_flag, 1'b0);
        run_cycles(6, SMALL);
        chk("R6 no retrigger while held", sag_flag, 1'b0);

        // restart on an above sample mid-count
        run_cycles(2, BIG);
        run_cycles(3, SMALL);
        run_cycles(1, BIG);
        run_cycles(4, SMALL);
        chk("R5 restarted count", sag_flag, 1'b0);
        run_cycles(1, SMALL);
        chk("R5 set after full new count", sag_flag, 1'b1);

        // set and clear in the same clock
        run_cycles(2, BIG);
        clear_flag();
        run_cycles(4, SMALL);
        flag_clr = 1'b1;
        step(1'b1, 24'(SMALL), 1'b1);
        chk("R7 set wins over clear", sag_flag, 1'b1);
        clear_flag();
        chk("R7 clear after set", sag_flag, 1'b0);

        // interrupt gating
        run_cycles(2, BIG);
        irq_en = 1'b0;
        run_cycles(5, SMALL);
        chk("R8 flag set with enable low", sag_flag, 1'b1);
        chk("R8 irq masked", sag_irq, 1'b0);
        irq_en = 1'b1;
        #1 chk("R8 irq follows enable", sag_irq, 1'b1);
        irq_en = 1'b0;
        #1 chk("R8 irq drops with enable", sag_irq, 1'b0);
        irq_en = 1'b1;

        // illegal cycle value 0 acts as 2
        run_cycles(2, BIG);
        clear_flag();
        sag_cycles = 8'd0;
        run_cycles(2, SMALL);
        chk("R4 not before 2nd pulse", sag_flag, 1'b0);
        step(1'b1, 24'(SMALL), 1'b1);
        chk("R4 set on 2nd pulse", sag_flag, 1'b1);

        // value 1 also acts as 2
        run_cycles(2, BIG);
        clear_flag();
        sag_cycles = 8'd1;
        run_cycles(3, SMALL);
        chk("R4 value 1 acts as 2", sag_flag, 1'b1);

        // zero threshold
        run_cycles(2, BIG);
        clear_flag();
        sag_cycles = 8'd2;
        sag_level  = 16'h0001;
        run_cycles(6, 0);
        chk("R2 level 1 never sags", sag_flag, 1'b0);
        sag_level = 16'h0000;
        run_cycles(6, 0);
        chk("R2 level 0 never sags", sag_flag, 1'b0);

        // pulse coincident with recovery is not counted
        sag_level = 16'h1000;
        run_cycles(2, SMALL);
        step(1'b1, 24'(BIG), 1'b1);
        for (int k = 0; k < 7; k++) step(1'b1, 24'(SMALL), 1'b0);
        chk("R10 pulse with recovery ignored", sag_flag, 1'b0);

        // boundary of the compare, negative half-waves included
        run_cycles(2, BIG);
        run_cycles(6, 32'h100000);
        chk("R1 equal magnitude not below", sag_flag, 1'b0);
        run_cycles(3, 32'h0FFFFF);
        chk("R1 just below sets", sag_flag, 1'b1);
        run_cycles(2, BIG);
        clear_flag();
        for (int c = 0; c < 3; c++) begin
            for (int k = 0; k < 8; k++) step(k % 2 == 0, 24'h800000, k == 0);
        end
        chk("R1 most negative code is large", sag_flag, 1'b0);

        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule